// File: doc/BRIEF.md
# Row Command Packet Decoder

This block sits behind the three row-control pins of a packet-based DRAM device. It assembles a 24-bit row packet from eight consecutive receive ticks of three bits each, decides from a two-bit framing pair whether a packet is present and whether it is addressed to this device, and separates activate packets from row-operation packets. A framing pair with both bits set is a broadcast that every device accepts. The same pair also supplies the top bit of the five-bit device address.

Activate packets yield a bank and a row address. Row-operation packets carry an 11-bit opcode whose bits can request several commands in one packet: precharge, refresh-activate, refresh-precharge, power-down, nap, conditional nap, attention and relax. Two further codes request temperature calibration. The block keeps a 9-bit refresh row counter. A refresh-activate uses that counter as its row address, and the counter advances only when the bank field addresses the highest bank. Each decoded result is a one-clock strobe that power-state and bank-control logic can consume.

Top module: `rowpkt_decoder`

## Requirements
- R1: The decoder stays idle until it samples a tick whose framing pair, row_in[2:1], is nonzero; that tick is tick 0 of a packet and the next seven ticks complete it. Packed with tick 0 in the most significant bits, the 24-bit word holds framing T at bit 23, framing F at bit 22, device bits [3:0] at 21:18, bank [4:0] at 17:13, an ignored bit at 12, opcode bits 10 and 9 at 11:10, the type bit at 9, and bits 8:0 carrying either the row address or opcode bits 8..0.
- R2: pkt_valid pulses high for exactly one clock, in the clock after the edge that captures tick 7, for every packet whatever its address. All strobes last that same single clock, and a new packet may start on the very next tick.
- R3: dev_match is set in the pkt_valid clock by this rule: T/F = 1/1 always matches (broadcast); 1/0 matches when dev_id equals {0, device bits}; 0/1 matches when dev_id equals {1, device bits}.
- R4: No command strobe asserts for a packet whose dev_match is 0.
- R5: A packet with type bit 1 is an activate: act_stb pulses alone, bank_o takes the bank field and row_o takes bits 8:0. Opcode bits 10 and 9 and the ignored bit have no effect.
- R6: A packet with type bit 0 and opcode bits 2:0 = 000 raises one strobe for each set opcode bit: bit 10 precharge, 9 refresh-activate, 8 refresh-precharge, 7 power-down, 6 nap, 5 conditional nap, 4 attention, 3 relax. Any combination may appear in one packet.
- R7: Opcode bits 2:0 = 001 with bits 10:3 zero raises tcal_stb, and 010 with bits 10:3 zero raises tcen_stb.
- R8: The attention request is dropped when the packet is a broadcast (T/F = 1/1).
- R9: A matched refresh-activate outputs the refresh counter on row_o, and the counter increments (wrapping 511 to 0) only when the bank field is 31. An unmatched packet leaves the counter unchanged.
- R10: Reset clears every output and the refresh counter.
- R11: An all-zero opcode, codes 011 to 111 in opcode bits 2:0, and codes 001 or 010 with any of bits 10:3 set raise no strobe, though pkt_valid still pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive tick clock, one row tick per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| row_in | input | 3 | Row pins sampled on each tick; [2:1] is the framing pair at tick 0 |
| dev_id | input | 5 | Device address of this device |
| pkt_valid | output | 1 | One-clock pulse after a full packet was captured |
| dev_match | output | 1 | Packet addressed to this device or broadcast |
| bank_o | output | 5 | Bank field of the last packet |
| row_o | output | 9 | Activate row, or refresh row for refresh-activate, else 0 |
| act_stb | output | 1 | Activate request |
| prer_stb | output | 1 | Precharge request |
| refa_stb | output | 1 | Refresh-activate request |
| refp_stb | output | 1 | Refresh-precharge request |
| pdn_stb | output | 1 | Power-down request |
| nap_stb | output | 1 | Nap request |
| napc_stb | output | 1 | Conditional nap request |
| attn_stb | output | 1 | Attention request (not for broadcast) |
| rlx_stb | output | 1 | Relax request |
| tcal_stb | output | 1 | Temperature calibrate request |
| tcen_stb | output | 1 | Temperature calibrate-enable request |

## Verification
Every result of a packet is registered on the edge that captures tick 7, so it is due one clock after the eighth tick is driven. The bench drives each tick on a falling edge and reads all outputs at the falling edge that follows the eighth rising edge. It reads them again one clock later to confirm that the pulses have ended. For back-to-back packets the first packet's results are read at the same falling edge that drives the second packet's tick 0. The refresh counter's effect shows only in the row_o of a later refresh packet, so the counter is checked through sequences of refresh packets.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;

    localparam int LANES   = 3;
    localparam int TICKS   = 8;
    localparam int PKT_W   = LANES * TICKS;
    localparam int CNT_W   = $clog2(TICKS);
    localparam int DEV_W   = 5;
    localparam int DRL_W   = DEV_W - 1;
    localparam int BANK_W  = 5;
    localparam int ROW_W   = 9;
    localparam int OP_W    = 11;
    localparam int HI_W    = OP_W - ROW_W;

    // word field positions (tick 0 in the most significant bits)
    localparam int POS_T   = PKT_W - 1;
    localparam int POS_F   = PKT_W - 2;
    localparam int DRL_LO  = POS_F - DRL_W;
    localparam int BANK_LO = DRL_LO - BANK_W;
    localparam int RSV_POS = BANK_LO - 1;
    localparam int HI_LO   = RSV_POS - HI_W;
    localparam int TYPE_POS = HI_LO - 1;

    // opcode bit assignments
    localparam int OPB_PRE   = 10;
    localparam int OPB_REFA  = 9;
    localparam int OPB_REFP  = 8;
    localparam int OPB_PDN   = 7;
    localparam int OPB_NAP   = 6;
    localparam int OPB_NAPC  = 5;
    localparam int OPB_ATTN  = 4;
    localparam int OPB_RLX   = 3;
    localparam int SUB_W     = 3;

    localparam logic [SUB_W-1:0] SUB_MULTI = 3'b000;
    localparam logic [SUB_W-1:0] SUB_TCAL  = 3'b001;
    localparam logic [SUB_W-1:0] SUB_TCEN  = 3'b010;

    typedef enum logic {DS_IDLE, DS_BUSY} ds_state_e;

    typedef struct packed {
        logic act;
        logic prer;
        logic refa;
        logic refp;
        logic pdn;
        logic nap;
        logic napc;
        logic attn;
        logic rlx;
        logic tcal;
        logic tcen;
    } row_cmd_t;

    function automatic logic dev_select(input logic t, input logic f,
                                        input logic [DRL_W-1:0] lo,
                                        input logic [DEV_W-1:0] id);
        logic hit;
        case ({t, f})
            2'b11:   hit = 1'b1;
            2'b10:   hit = (id == {1'b0, lo});
            2'b01:   hit = (id == {1'b1, lo});
            default: hit = 1'b0;
        endcase
        return hit;
    endfunction

    function automatic row_cmd_t decode_ops(input logic av,
                                            input logic [OP_W-1:0] op,
                                            input logic bcast);
        row_cmd_t c;
        logic upper_clear;
        c = '0;
        upper_clear = (op[OP_W-1:SUB_W] == '0);
        if (av) begin
            c.act = 1'b1;
        end else begin
            case (op[SUB_W-1:0])
                SUB_MULTI: begin
                    c.prer = op[OPB_PRE];
                    c.refa = op[OPB_REFA];
                    c.refp = op[OPB_REFP];
                    c.pdn  = op[OPB_PDN];
                    c.nap  = op[OPB_NAP];
                    c.napc = op[OPB_NAPC];
                    c.attn = op[OPB_ATTN] & ~bcast;
                    c.rlx  = op[OPB_RLX];
                end
                SUB_TCAL: c.tcal = upper_clear;
                SUB_TCEN: c.tcen = upper_clear;
                default:  c = '0;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/rowdec_deser.sv
module rowdec_deser
    import rowdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] row_in,
    output logic [PKT_W-1:0] word_o,
    output logic             last_o
);
    localparam int SH_W = PKT_W - LANES;

    ds_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SH_W-1:0]  sh_q;
    logic             frame_seen;

    assign frame_seen = |row_in[LANES-1 -: 2];
    assign last_o     = (state_q == DS_BUSY) && (cnt_q == CNT_W'(TICKS - 1));
    assign word_o     = {sh_q, row_in};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DS_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
        end else begin
            sh_q <= {sh_q[SH_W-LANES-1:0], row_in};
            case (state_q)
                DS_IDLE: begin
                    if (frame_seen) begin
                        state_q <= DS_BUSY;
                        cnt_q   <= CNT_W'(1);
                    end
                end
                DS_BUSY: begin
                    if (cnt_q == CNT_W'(TICKS - 1)) begin
                        state_q <= DS_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: state_q <= DS_IDLE;
            endcase
        end
    end

    AST_LAST_ENDS_PACKET: assert property (@(posedge clk) disable iff (rst)
        last_o |=> (state_q == DS_IDLE)); // R2
    AST_IDLE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        (state_q == DS_IDLE && !frame_seen) |=> (state_q == DS_IDLE)); // R1

endmodule

// File: rtl/rowdec_refr.sv
module rowdec_refr
    import rowdec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [ROW_W-1:0] row_o
);
    logic [ROW_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)      cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + ROW_W'(1);
    end

    assign row_o = cnt_q;

    AST_REFR_STEP: assert property (@(posedge clk) disable iff (rst)
        inc |=> (cnt_q == $past(cnt_q) + ROW_W'(1))); // R9
    AST_REFR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/rowdec_cmd.sv
module rowdec_cmd
    import rowdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              last_i,
    input  logic [PKT_W-1:0]  word_i,
    input  logic [DEV_W-1:0]  dev_id,
    input  logic [ROW_W-1:0]  refr_i,
    output logic              refr_inc_o,
    output logic              pkt_valid_q,
    output logic              dev_match_q,
    output logic [BANK_W-1:0] bank_q,
    output logic [ROW_W-1:0]  row_q,
    output row_cmd_t          cmd_q
);
    logic              fr_t, fr_f, bcast, dm_c, av;
    logic [DRL_W-1:0]  dev_lo;
    logic [BANK_W-1:0] bank_c;
    logic [OP_W-1:0]   op_c;
    row_cmd_t          dec_c;
    logic              bcast_q;
    logic              unused_rsv;

    assign fr_t       = word_i[POS_T];
    assign fr_f       = word_i[POS_F];
    assign dev_lo     = word_i[DRL_LO +: DRL_W];
    assign bank_c     = word_i[BANK_LO +: BANK_W];
    assign av         = word_i[TYPE_POS];
    assign op_c       = {word_i[HI_LO +: HI_W], word_i[ROW_W-1:0]};
    assign unused_rsv = word_i[RSV_POS];
    assign bcast      = fr_t & fr_f;
    assign dm_c       = dev_select(fr_t, fr_f, dev_lo, dev_id);
    assign dec_c      = decode_ops(av, op_c, bcast);
    assign refr_inc_o = last_i & dm_c & dec_c.refa & (&bank_c);

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_valid_q <= 1'b0;
            dev_match_q <= 1'b0;
            bank_q      <= '0;
            row_q       <= '0;
            cmd_q       <= '0;
            bcast_q     <= 1'b0;
        end else begin
            pkt_valid_q <= last_i;
            dev_match_q <= last_i & dm_c;
            bcast_q     <= last_i & bcast;
            cmd_q       <= (last_i && dm_c) ? dec_c : '0;
            if (last_i) begin
                bank_q <= bank_c;
                if (av)              row_q <= word_i[ROW_W-1:0];
                else if (dec_c.refa) row_q <= refr_i;
                else                 row_q <= '0;
            end
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pkt_valid_q |=> !pkt_valid_q); // R2
    AST_MATCH_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        dev_match_q |-> pkt_valid_q); // R3
    AST_STB_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
        (cmd_q != '0) |-> (dev_match_q && pkt_valid_q)); // R4
    AST_ACT_ALONE: assert property (@(posedge clk) disable iff (rst)
        cmd_q.act |-> ($countones(cmd_q) == 1)); // R5
    AST_TEMP_ALONE: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.tcal || cmd_q.tcen) |-> ($countones(cmd_q) == 1)); // R7
    AST_NO_BCAST_ATTN: assert property (@(posedge clk) disable iff (rst)
        cmd_q.attn |-> !bcast_q); // R8

endmodule

// File: rtl/rowpkt_decoder.sv
module rowpkt_decoder
    import rowdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  row_in,
    input  logic [DEV_W-1:0]  dev_id,
    output logic              pkt_valid,
    output logic              dev_match,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o,
    output logic              act_stb,
    output logic              prer_stb,
    output logic              refa_stb,
    output logic              refp_stb,
    output logic              pdn_stb,
    output logic              nap_stb,
    output logic              napc_stb,
    output logic              attn_stb,
    output logic              rlx_stb,
    output logic              tcal_stb,
    output logic              tcen_stb
);
    logic [PKT_W-1:0] word;
    logic             last;
    logic             refr_inc;
    logic [ROW_W-1:0] refr_row;
    row_cmd_t         cmd;

    rowdec_deser u_deser (
        .clk    (clk),
        .rst    (rst),
        .row_in (row_in),
        .word_o (word),
        .last_o (last)
    );

    rowdec_refr u_refr (
        .clk   (clk),
        .rst   (rst),
        .inc   (refr_inc),
        .row_o (refr_row)
    );

    rowdec_cmd u_cmd (
        .clk         (clk),
        .rst         (rst),
        .last_i      (last),
        .word_i      (word),
        .dev_id      (dev_id),
        .refr_i      (refr_row),
        .refr_inc_o  (refr_inc),
        .pkt_valid_q (pkt_valid),
        .dev_match_q (dev_match),
        .bank_q      (bank_o),
        .row_q       (row_o),
        .cmd_q       (cmd)
    );

    assign act_stb  = cmd.act;
    assign prer_stb = cmd.prer;
    assign refa_stb = cmd.refa;
    assign refp_stb = cmd.refp;
    assign pdn_stb  = cmd.pdn;
    assign nap_stb  = cmd.nap;
    assign napc_stb = cmd.napc;
    assign attn_stb = cmd.attn;
    assign rlx_stb  = cmd.rlx;
    assign tcal_stb = cmd.tcal;
    assign tcen_stb = cmd.tcen;

endmodule

// File: tb/tb_rowpkt_decoder.sv
`timescale 1ns/1ps
module tb_rowpkt_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] row_in = '0;
    logic [4:0] dev_id = '0;
    logic       pkt_valid, dev_match;
    logic [4:0] bank_o;
    logic [8:0] row_o;
    logic act_stb, prer_stb, refa_stb, refp_stb, pdn_stb, nap_stb;
    logic napc_stb, attn_stb, rlx_stb, tcal_stb, tcen_stb;
    logic [10:0] stb;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    rowpkt_decoder dut (
        .clk(clk), .rst(rst), .row_in(row_in), .dev_id(dev_id),
        .pkt_valid(pkt_valid), .dev_match(dev_match), .bank_o(bank_o), .row_o(row_o),
        .act_stb(act_stb), .prer_stb(prer_stb), .refa_stb(refa_stb), .refp_stb(refp_stb),
        .pdn_stb(pdn_stb), .nap_stb(nap_stb), .napc_stb(napc_stb), .attn_stb(attn_stb),
        .rlx_stb(rlx_stb), .tcal_stb(tcal_stb), .tcen_stb(tcen_stb)
    );

    assign stb = {act_stb, prer_stb, refa_stb, refp_stb, pdn_stb, nap_stb,
                  napc_stb, attn_stb, rlx_stb, tcal_stb, tcen_stb};

    function automatic logic [23:0] mk(input logic t, input logic f, input logic [3:0] dr,
                                       input logic [4:0] bk, input logic av,
                                       input logic [1:0] hi, input logic [8:0] lo);
        return {t, f, dr, bk, 1'b0, hi, av, lo};
    endfunction

    // {dev_id, word, exp_dm, exp_stb, exp_bank, exp_row}
    localparam int NV = 13;
    localparam logic [54:0] VEC [0:NV-1] = '{
        {5'b10110, mk(0,1,4'b0110,5'd7,1,2'b11,9'h1A5) | 24'h001000, 1'b1, 11'b100_0000_0000, 5'd7, 9'h1A5},
        {5'b10110, mk(0,1,4'b0111,5'd7,1,2'b00,9'h0F0), 1'b0, 11'd0, 5'd7, 9'h0F0},
        {5'b10110, mk(1,1,4'b0000,5'd3,0,2'b10,9'b000101000), 1'b1, 11'b010_0001_0100, 5'd3, 9'd0},
        {5'b10110, mk(1,1,4'b0000,5'd3,0,2'b00,9'b000010000), 1'b1, 11'd0, 5'd3, 9'd0},
        {5'b10110, mk(0,1,4'b0110,5'd4,0,2'b00,9'b000010000), 1'b1, 11'b000_0000_1000, 5'd4, 9'd0},
        {5'b10110, mk(1,0,4'b0110,5'd1,0,2'b00,9'b011000000), 1'b0, 11'd0, 5'd1, 9'd0},
        {5'b00110, mk(1,0,4'b0110,5'd1,0,2'b00,9'b011000000), 1'b1, 11'b000_0110_0000, 5'd1, 9'd0},
        {5'b10110, mk(0,1,4'b0110,5'd2,0,2'b00,9'h001), 1'b1, 11'b000_0000_0010, 5'd2, 9'd0},
        {5'b10110, mk(0,1,4'b0110,5'd2,0,2'b00,9'h002), 1'b1, 11'b000_0000_0001, 5'd2, 9'd0},
        {5'b10110, mk(0,1,4'b0110,5'd2,0,2'b10,9'h001), 1'b1, 11'd0, 5'd2, 9'd0},
        {5'b10110, mk(0,1,4'b0110,5'd2,0,2'b00,9'h003), 1'b1, 11'd0, 5'd2, 9'd0},
        {5'b10110, mk(0,1,4'b0110,5'd2,0,2'b00,9'h000), 1'b1, 11'd0, 5'd2, 9'd0},
        {5'b10110, mk(0,1,4'b0110,5'd9,0,2'b00,9'b100000000), 1'b1, 11'b000_1000_0000, 5'd9, 9'd0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drives 8 ticks; returns at the falling edge where the results are due
    task automatic send_pkt(input logic [23:0] w, input logic [4:0] id);
        dev_id = id;
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            row_in = w[23 - 3*t -: 3];
        end
        @(negedge clk);
        row_in = 3'b000;
    endtask

    task automatic check_refresh(input logic [4:0] bk, input logic [8:0] exp_row, input string tag);
        send_pkt(mk(0,1,4'b0110,bk,0,2'b01,9'd0), 5'b10110);
        chk({tag, " refa strobe"}, {31'd0, refa_stb}, 32'd1);
        chk({tag, " refresh row"}, {23'd0, row_o}, {23'd0, exp_row});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10 reset outputs", {12'd0, pkt_valid, dev_match, bank_o, row_o, stb},
            32'd0);

        // R1: framing pair 00 with a lower bit set keeps the decoder idle
        begin
            logic seen = 1'b0;
            dev_id = 5'b10110;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                row_in = 3'b001;
                seen |= pkt_valid;
            end
            @(negedge clk);
            row_in = 3'b000;
            seen |= pkt_valid;
            @(negedge clk);
            seen |= pkt_valid;
            chk("R1 idle without framing", {31'd0, seen}, 32'd0);
        end

        // table walk: R3 R4 R5 R6 R7 R8 R11, with R2 pulse end
        for (int i = 0; i < NV; i++) begin
            logic [54:0] v;
            v = VEC[i];
            send_pkt(v[49:26], v[54:50]);
            chk($sformatf("R2 vec%0d pkt_valid", i), {31'd0, pkt_valid}, 32'd1);
            chk($sformatf("R3 vec%0d dev_match", i), {31'd0, dev_match}, {31'd0, v[25]});
            chk($sformatf("R4 R5 R6 R7 R8 R11 vec%0d strobes", i), {21'd0, stb}, {21'd0, v[24:14]});
            chk($sformatf("R5 vec%0d bank", i), {27'd0, bank_o}, {27'd0, v[13:9]});
            chk($sformatf("R5 vec%0d row", i), {23'd0, row_o}, {23'd0, v[8:0]});
            @(negedge clk);
            chk($sformatf("R2 vec%0d pulse ended", i), {20'd0, pkt_valid, stb}, 32'd0);
        end

        // R2: back-to-back packets with no idle tick between them
        begin
            logic [47:0] pair;
            pair = {mk(0,1,4'b0110,5'd1,1,2'b00,9'h011), mk(0,1,4'b0110,5'd2,1,2'b00,9'h022)};
            dev_id = 5'b10110;
            for (int t = 0; t < 16; t++) begin
                @(negedge clk);
                if (t == 8) begin
                    chk("R2 first of pair valid", {31'd0, pkt_valid & act_stb}, 32'd1);
                    chk("R2 first of pair row", {23'd0, row_o}, 32'h011);
                end
                row_in = pair[47 - 3*t -: 3];
            end
            @(negedge clk);
            row_in = 3'b000;
            chk("R2 second of pair valid", {31'd0, pkt_valid & act_stb}, 32'd1);
            chk("R2 second of pair row", {23'd0, row_o}, 32'h022);
        end

        // R9: refresh counter
        check_refresh(5'd5,  9'd0, "R9 first");
        check_refresh(5'd31, 9'd0, "R9 top bank");
        check_refresh(5'd5,  9'd1, "R9 after step");
        send_pkt(mk(0,1,4'b0111,5'd31,0,2'b01,9'd0), 5'b10110);
        chk("R9 R4 unmatched refresh", {30'd0, dev_match, refa_stb}, 32'd0);
        check_refresh(5'd5,  9'd1, "R9 unmatched no step");
        for (int k = 0; k < 510; k++) begin
            send_pkt(mk(0,1,4'b0110,5'd31,0,2'b01,9'd0), 5'b10110);
        end
        check_refresh(5'd31, 9'd511, "R9 last row");
        check_refresh(5'd5,  9'd0, "R9 wrap");

        // R10: reset clears the refresh counter
        check_refresh(5'd31, 9'd0, "R9 pre reset");
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R10 outputs after reset", {12'd0, pkt_valid, dev_match, bank_o, row_o, stb}, 32'd0);
        check_refresh(5'd5, 9'd0, "R10 counter cleared");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule